// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. A start pulse sends it through a fixed sequence. First it closes the integrator reset switch for a fixed auto-zero interval. Next it connects the unknown input to the integrator for a programmable run-up length T1, counted in clock cycles. Last it connects a reference of opposite polarity and counts cycles until the zero-crossing comparator reports that the integrator has returned to zero.

Because the average input equals the reference times the run-down count divided by T1, the run-down count is the conversion result when T1 is held fixed. For noise rejection, T1 is normally set to one period of the power-line frequency. If the run-down lasts too long, the block stops, saturates the result and flags an overrange. A busy output covers the whole conversion. A one-cycle end-of-conversion pulse marks the moment a new result becomes valid.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset all three switch controls, `busy`, `eoc`, `result` and `overrange` are 0.
- R2: At most one switch control is high in any cycle. `busy` is high exactly when one of them is high, and all are low while idle or while `eoc` is high.
- R3: A start accepted at a clock edge makes `sw_reset` high for exactly AZ_CYCLES cycles, beginning in the next cycle.
- R4: `sw_input` is high for exactly T1 cycles right after auto-zero. T1 is `runup_len` sampled with the accepted start, and a value of 0 is treated as 1.
- R5: During run-down, `sw_ref` is high and a counter starts at 0 and advances once per cycle. In the first cycle where `cmp_zero` is 1, that count goes to `result` and `overrange` is cleared. The run-down phase therefore lasts count+1 cycles.
- R6: If the count reaches 2·T1 with `cmp_zero` still 0, the conversion ends with `result` = 2·T1 and `overrange` = 1. A trip seen at exactly 2·T1 is a normal result.
- R7: `eoc` is a single-cycle pulse in the cycle after the last busy cycle. `result` and `overrange` change only in that cycle and hold otherwise.
- R8: A start is accepted only when the block is idle, meaning neither busy nor showing `eoc`. A start while busy or during `eoc` has no effect.
- R9: Changes of `runup_len` after a start is accepted do not affect the run-up length of that conversion.
- R10: `cmp_zero` is ignored outside the run-down phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled each cycle |
| runup_len | input | CW | Run-up length T1 in cycles (0 means 1) |
| cmp_zero | input | 1 | Comparator: integrator at or past zero |
| sw_reset | output | 1 | Integrator reset (auto-zero) switch |
| sw_input | output | 1 | Connect unknown input to integrator |
| sw_ref | output | 1 | Connect opposite-polarity reference |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| result | output | CW+1 | Run-down count of last conversion |
| overrange | output | 1 | Last conversion hit the 2·T1 limit |

## Verification
A wrong phase counter or state shows up at once at the switch pins. Auto-zero or run-up ends a cycle early or late, so the per-conversion counts of `sw_reset` and `sw_input` cycles differ from AZ_CYCLES and T1 by the time `eoc` appears. A stuck or mis-compared run-down count shows up at the first `eoc` as a wrong `result`, a wrong `overrange`, or a busy length that does not match AZ_CYCLES + T1 + count + 1. The bench drives a behavioral integrator from the switch pins, so every one of these errors is caught within one conversion.

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int CW        = 16,
  parameter int AZ_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] runup_len,
  input  logic          cmp_zero,
  output logic          sw_reset,
  output logic          sw_input,
  output logic          sw_ref,
  output logic          busy,
  output logic          eoc,
  output logic [CW:0]   result,
  output logic          overrange
);
  localparam int RW = CW + 1;
  localparam logic [RW-1:0] AZ_LAST = RW'(AZ_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_AZ, S_RUNUP, S_RUNDOWN, S_DONE} st_t;

  st_t           st;
  logic [RW-1:0] cnt;
  logic [CW-1:0] t1q;
  logic [RW-1:0] t1_last, lim;

  assign t1_last = {1'b0, t1q} - RW'(1);
  assign lim     = {t1q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      t1q       <= CW'(1);
      result    <= '0;
      overrange <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_AZ;
          cnt <= '0;
          t1q <= (runup_len == '0) ? CW'(1) : runup_len;
        end
        S_AZ: if (cnt == AZ_LAST) begin
          st  <= S_RUNUP;
          cnt <= '0;
        end else cnt <= cnt + RW'(1);
        S_RUNUP: if (cnt == t1_last) begin
          st  <= S_RUNDOWN;
          cnt <= '0;
        end else cnt <= cnt + RW'(1);
        S_RUNDOWN: if (cmp_zero) begin
          result    <= cnt;
          overrange <= 1'b0;
          st        <= S_DONE;
        end else if (cnt == lim) begin
          result    <= lim;
          overrange <= 1'b1;
          st        <= S_DONE;
        end else cnt <= cnt + RW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sw_reset = (st == S_AZ);
  assign sw_input = (st == S_RUNUP);
  assign sw_ref   = (st == S_RUNDOWN);
  assign busy     = sw_reset | sw_input | sw_ref;
  assign eoc      = (st == S_DONE);
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int CW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        sw_reset,
  input logic        sw_input,
  input logic        sw_ref,
  input logic        busy,
  input logic        eoc,
  input logic [CW:0] result,
  input logic        overrange
);
  p_switch_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_reset, sw_input, sw_ref}));

  p_busy_matches_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (sw_reset | sw_input | sw_ref));

  p_autozero_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sw_reset);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));

  p_ovr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(overrange));

  p_eoc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  p_eoc_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> ($past(busy) && !busy));

  p_idle_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !eoc && start) |=> busy);

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && start) |=> !busy);
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sw_reset(sw_reset),
  .sw_input(sw_input), .sw_ref(sw_ref), .busy(busy), .eoc(eoc),
  .result(result), .overrange(overrange)
);

// File: tb/dual_slope_seq_test.sv
module dual_slope_seq_test;
  localparam int CW = 16;
  localparam int AZ = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] runup_len = '0;
  logic          cmp_zero;
  logic          sw_reset, sw_input, sw_ref, busy, eoc, overrange;
  logic [CW:0]   result;

  int errors = 0;
  int checks = 0;
  int acc, vin_r, vref_r;
  logic force_trip = 1'b0;

  int q_res[$], q_ovr[$], q_busy[$], q_ru[$];
  int bcnt = 0, azc = 0, ruc = 0;

  always #2 clk = ~clk;

  dual_slope_seq #(.CW(CW), .AZ_CYCLES(AZ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .runup_len(runup_len),
    .cmp_zero(cmp_zero), .sw_reset(sw_reset), .sw_input(sw_input),
    .sw_ref(sw_ref), .busy(busy), .eoc(eoc), .result(result),
    .overrange(overrange)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n)        acc <= 0;
    else if (sw_reset) acc <= 0;
    else if (sw_input) acc <= acc + vin_r;
    else if (sw_ref)   acc <= acc - vref_r;

  assign cmp_zero = force_trip || (acc <= 0);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (busy)     bcnt++;
    if (sw_reset) azc++;
    if (sw_input) ruc++;
    if (eoc) begin
      if (q_res.size() == 0) chk("R7 unexpected eoc", 1, 0);
      else begin
        chk("R5 result", int'(result), q_res.pop_front());
        chk("R6 overrange", int'(overrange), q_ovr.pop_front());
        chk("R7 busy length", bcnt, q_busy.pop_front());
        chk("R3 autozero cycles", azc, AZ);
        chk("R4 runup cycles", ruc, q_ru.pop_front());
      end
      bcnt = 0; azc = 0; ruc = 0;
    end
  end

  task automatic convert(input int t1, input int vin, input int vref, input bit disturb);
    int t1e, k, rd;
    t1e = (t1 == 0) ? 1 : t1;
    k = (vin * t1e + vref - 1) / vref;
    if (k > 2 * t1e) begin
      q_res.push_back(2 * t1e); q_ovr.push_back(1); rd = 2 * t1e + 1;
    end else begin
      q_res.push_back(k); q_ovr.push_back(0); rd = k + 1;
    end
    q_busy.push_back(AZ + t1e + rd);
    q_ru.push_back(t1e);
    @(negedge clk);
    vin_r = vin; vref_r = vref; runup_len = CW'(t1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (2) @(negedge clk);
      start = 1'b1; runup_len = CW'(3);    // R8 start while busy, R9 length change
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      force_trip = 1'b1;                   // R10 trip during run-up
      repeat (2) @(negedge clk);
      force_trip = 1'b0;
    end
    while (!eoc) @(negedge clk);
    if (disturb) start = 1'b1;             // R8 start during eoc
    @(negedge clk);
    start = 1'b0;
    chk("R7 eoc single pulse", int'(eoc), 0);
    if (disturb) chk("R8 start in eoc ignored", int'(busy), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vin_r = 0; vref_r = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 eoc", int'(eoc), 0);
    chk("R1 switches", int'({sw_reset, sw_input, sw_ref}), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 overrange", int'(overrange), 0);

    convert(10, 3, 5, 1'b0);   // R5 nominal: ceil(30/5)=6
    convert(16, 7, 3, 1'b0);   // R6 overrange: 38 > 32
    convert(20, 0, 4, 1'b0);   // R5 zero input, also clears overrange
    convert(8, 4, 2, 1'b0);    // R6 boundary: exactly 2*T1 is normal
    convert(0, 5, 3, 1'b0);    // R4 zero length treated as 1
    convert(12, 5, 4, 1'b1);   // R8 R9 R10 disturbances, result 15
    convert(40, 9, 7, 1'b0);   // R5 ceil(360/7)=52

    chk("R7 all results seen", q_res.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule